// File: doc/BRIEF.md
# Dual Synthesizer Power and Divider-Hold Controller

This block sequences power for two independent frequency-synthesizer channels. Each channel gets a two-bit mode word, a powerdown bit and a tri-state bit, and the block turns it into enables for the channel's prescaler, phase detector and charge pump. It also drives a charge pump output-enable and a hold line. The hold line pins the channel's reference and feedback dividers at their load point.

Powerdown can be immediate, or it can be deferred until the charge pump finishes its next pulse. On wake-up, the dividers of a channel stay at load for a programmable number of settling cycles. After that, both dividers are released on the same edge.

A separate two-bit counter-reset selector can hold the divider pair of either channel, or of both, independently of power state. The oscillator buffer is shared by the two channels and is gated off only when neither channel is powered. The register interface that supplies the mode bits is outside the block and keeps working in every power state. The mode inputs are treated as synchronous levels sampled on each rising edge.

Top module: `pll_pwr_ctrl`

## Requirements
- R1: With mode word powerdown=0 and tri-state=0 on a released channel, that channel's prescaler, phase detector and charge pump enables and its charge pump output-enable are 1 and its divider hold is 0.
- R2: With powerdown=0 and tri-state=1, the channel's three enables stay 1 but its charge pump output-enable is 0 from the next rising edge on; divider hold is unaffected.
- R3: With powerdown=1 and tri-state=1 (asynchronous), an active channel is down after the next rising edge: enables and output-enable 0, divider hold 1.
- R4: With powerdown=1 and tri-state=0 (synchronous), the channel stays powered until a charge-pump-done strobe is sampled while the request is already pending; it is down one edge after that strobe. A strobe in the same cycle the request first appears does not count.
- R5: If powerdown returns to 0 while a synchronous powerdown is pending, the channel stays powered with its dividers released, and later strobes have no effect.
- R6: Switching to asynchronous mode while a synchronous request is pending powers the channel down on the next edge.
- R7: When powerdown falls on a down channel, its enables rise after one edge, and its divider hold stays 1 for exactly SETTLE_CYC edges after that before both dividers are released together.
- R8: A powerdown request during the settling window powers the channel down on the next edge; a later wake-up restarts the full settling count.
- R9: The oscillator buffer enable is 0 only while both channels are down and is 1 one edge after either channel starts waking.
- R10: Counter-reset selector bit 0 holds channel 0's dividers and bit 1 holds channel 1's (value 3 holds both, 0 holds none), one edge after the selector changes. It overrides a pending release and does not change any power enable.
- R11: During and right after reset, both channels are down, the oscillator buffer is off and all divider holds are 1.
- R12: Mode changes on one channel do not alter the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwdnBit | input | 2 | Powerdown bit per channel (bit 0 = channel 0) |
| triBit | input | 2 | Tri-state / asynchronous bit per channel |
| cpPulseDone | input | 2 | Single-cycle strobe per channel at the end of a charge pump pulse |
| cntRstSel | input | 2 | Counter-reset selector; bit i holds channel i's dividers |
| prescEn | output | 2 | Prescaler enable per channel |
| phDetEn | output | 2 | Phase detector enable per channel |
| cpEn | output | 2 | Charge pump bias enable per channel |
| cpOutOe | output | 2 | Charge pump output drive enable (0 = high impedance) |
| divHold | output | 2 | Holds both reference and feedback dividers of a channel at load |
| oscBufEn | output | 1 | Shared reference oscillator buffer enable |

## Verification
Two things can meet on the same edge: a channel's wake-up settling count expiring, and a counter-reset selection holding that same channel. The bench wakes channel 1 with its counter-reset bit already set and holds that bit across the expiry edge. It then checks that the divider hold stays 1 while all power enables are 1, and that the hold falls one edge after the selector clears. A second collision is a charge-pump-done strobe that arrives in the very cycle a synchronous request appears. That strobe must be ignored, and the channel must go down only after a later strobe.

// File: rtl/pllpc_pkg.sv
package pllpc_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_DOWN     = 2'd0,
    CH_WAKE     = 2'd1,
    CH_RUN      = 2'd2,
    CH_SYNCWAIT = 2'd3
  } chState_t;

  // Strobes from the per-channel sequencer to the output datapath
  typedef struct packed {
    logic powered;   // analog blocks of the channel are biased
    logic released;  // dividers may count
    logic hiZ;       // registered tri-state request
  } chStrobe_t;

endpackage

// File: rtl/pllpc_ctrl.sv
module pllpc_ctrl
  import pllpc_pkg::*;
#(
  parameter int NCH        = NUM_CH,
  parameter int SETTLE_CYC = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic      [NCH-1:0]   pwdnReq,
  input  logic      [NCH-1:0]   triReq,
  input  logic      [NCH-1:0]   cpDone,
  output chStrobe_t [NCH-1:0]   strb
);

  localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chState_t       st, stNxt;
    logic [CW-1:0]  cnt, cntNxt;
    logic           hiZQ;

    always_comb begin
      stNxt  = st;
      cntNxt = cnt;
      unique case (st)
        CH_DOWN: begin
          if (!pwdnReq[i]) begin
            stNxt  = CH_WAKE;
            cntNxt = '0;
          end
        end
        CH_WAKE: begin
          if (pwdnReq[i]) begin
            stNxt = CH_DOWN;
          end else if (cnt == LAST) begin
            stNxt = CH_RUN;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        CH_RUN: begin
          if (pwdnReq[i] && triReq[i]) stNxt = CH_DOWN;
          else if (pwdnReq[i])         stNxt = CH_SYNCWAIT;
        end
        CH_SYNCWAIT: begin
          if (!pwdnReq[i])                 stNxt = CH_RUN;
          else if (triReq[i] || cpDone[i]) stNxt = CH_DOWN;
        end
        default: stNxt = CH_DOWN;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st   <= CH_DOWN;
        cnt  <= '0;
        hiZQ <= 1'b1;
      end else begin
        st   <= stNxt;
        cnt  <= cntNxt;
        hiZQ <= triReq[i];
      end
    end

    assign strb[i].powered  = (st != CH_DOWN);
    assign strb[i].released = (st == CH_RUN) || (st == CH_SYNCWAIT);
    assign strb[i].hiZ      = hiZQ;

    // R3: asynchronous powerdown takes one edge
    p_async_down_r3: assert property (@(posedge clk) disable iff (!rstN)
      (st == CH_RUN && pwdnReq[i] && triReq[i]) |=> (st == CH_DOWN));

    // R4: pending synchronous request without a strobe keeps waiting
    p_sync_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
      (st == CH_SYNCWAIT && pwdnReq[i] && !triReq[i] && !cpDone[i]) |=> (st == CH_SYNCWAIT));

    // R5: cancellation returns to running
    p_cancel_r5: assert property (@(posedge clk) disable iff (!rstN)
      (st == CH_SYNCWAIT && !pwdnReq[i]) |=> (st == CH_RUN));

    // R8: a request during settling aborts the wake-up
    p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
      (st == CH_WAKE && pwdnReq[i]) |=> (st == CH_DOWN));
  end

endmodule

// File: rtl/pllpc_dp.sv
module pllpc_dp
  import pllpc_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic                clk,
  input  logic                rstN,
  input  chStrobe_t [NCH-1:0] strb,
  input  logic      [NCH-1:0] rstSel,
  output logic      [NCH-1:0] prescEn,
  output logic      [NCH-1:0] phDetEn,
  output logic      [NCH-1:0] cpEn,
  output logic      [NCH-1:0] cpOutOe,
  output logic      [NCH-1:0] divHold,
  output logic                oscBufEn
);

  logic [NCH-1:0] rstSelQ;
  logic [NCH-1:0] anyPowered;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstSelQ <= '0;
    else       rstSelQ <= rstSel;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign prescEn[i]    = strb[i].powered;
    assign phDetEn[i]    = strb[i].powered;
    assign cpEn[i]       = strb[i].powered;
    assign cpOutOe[i]    = strb[i].powered && !strb[i].hiZ;
    assign divHold[i]    = !strb[i].released || rstSelQ[i];
    assign anyPowered[i] = strb[i].powered;

    // R7: released dividers imply a powered channel
    p_release_powered_r7: assert property (@(posedge clk) disable iff (!rstN)
      !divHold[i] |-> prescEn[i]);

    // R2: the output can only drive when the pump is biased
    p_oe_needs_cp_r2: assert property (@(posedge clk) disable iff (!rstN)
      cpOutOe[i] |-> cpEn[i]);

    // R10: a selected counter reset holds the dividers on the next edge
    p_rst_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      rstSel[i] |=> divHold[i]);
  end

  assign oscBufEn = |anyPowered;

  // R9: buffer off means every channel is parked
  p_osc_off_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !oscBufEn |-> (&divHold && !(|prescEn)));

endmodule

// File: rtl/pll_pwr_ctrl.sv
module pll_pwr_ctrl
  import pllpc_pkg::*;
#(
  parameter int SETTLE_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwdnBit,
  input  logic [1:0] triBit,
  input  logic [1:0] cpPulseDone,
  input  logic [1:0] cntRstSel,
  output logic [1:0] prescEn,
  output logic [1:0] phDetEn,
  output logic [1:0] cpEn,
  output logic [1:0] cpOutOe,
  output logic [1:0] divHold,
  output logic       oscBufEn
);

  chStrobe_t [NUM_CH-1:0] strb;

  pllpc_ctrl #(
    .NCH        (NUM_CH),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwdnReq (pwdnBit),
    .triReq  (triBit),
    .cpDone  (cpPulseDone),
    .strb    (strb)
  );

  pllpc_dp #(
    .NCH (NUM_CH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rstSel   (cntRstSel),
    .prescEn  (prescEn),
    .phDetEn  (phDetEn),
    .cpEn     (cpEn),
    .cpOutOe  (cpOutOe),
    .divHold  (divHold),
    .oscBufEn (oscBufEn)
  );

endmodule

// File: tb/pll_pwr_ctrl_tb.sv
module pll_pwr_ctrl_tb;

  localparam int SETTLE = 16;
  localparam int NVEC   = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] pwdnBit, triBit, cpPulseDone, cntRstSel;
  logic [1:0] prescEn, phDetEn, cpEn, cpOutOe, divHold;
  logic       oscBufEn;
  int         nChk = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  pll_pwr_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .pwdnBit(pwdnBit), .triBit(triBit),
    .cpPulseDone(cpPulseDone), .cntRstSel(cntRstSel),
    .prescEn(prescEn), .phDetEn(phDetEn), .cpEn(cpEn), .cpOutOe(cpOutOe),
    .divHold(divHold), .oscBufEn(oscBufEn)
  );

  // {pwdn, tri, cpDone, rstSel | en, oe, hold, osc}; bit 0 of each pair = channel 0
  localparam logic [14:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 1'b1}, // R1 normal
    {2'b00, 2'b01, 2'b00, 2'b00, 2'b11, 2'b10, 2'b00, 1'b1}, // R2 ch0 tri-state
    {2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b11, 2'b01, 1'b1}, // R10 reset ch0
    {2'b00, 2'b00, 2'b00, 2'b10, 2'b11, 2'b11, 2'b10, 1'b1}, // R10 reset ch1
    {2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 1'b1}, // R10 reset all
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 1'b1}, // R10 back to normal
    {2'b01, 2'b00, 2'b01, 2'b00, 2'b11, 2'b11, 2'b00, 1'b1}, // R4 same-cycle strobe ignored
    {2'b01, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 1'b1}, // R4 still pending
    {2'b01, 2'b00, 2'b01, 2'b00, 2'b10, 2'b10, 2'b01, 1'b1}, // R4 down after strobe
    {2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 1'b0}  // R3 R9 ch1 async, all off
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] en, input logic [1:0] oe,
                     input logic [1:0] hold, input logic osc);
    logic [10:0] act, exp;
    act = {prescEn, phDetEn, cpEn, cpOutOe, divHold, oscBufEn};
    exp = {en, en, en, oe, hold, osc};
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] pw, input logic [1:0] tr,
                       input logic [1:0] cp, input logic [1:0] rs);
    pwdnBit = pw; triBit = tr; cpPulseDone = cp; cntRstSel = rs;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    drive(2'b11, 2'b11, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    chk("R11 in reset", 2'b00, 2'b00, 2'b11, 1'b0);
    rstN = 1'b1;
    tick();
    chk("R11 after reset", 2'b00, 2'b00, 2'b11, 1'b0);

    // wake both channels
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R7 R9 both waking", 2'b11, 2'b11, 2'b11, 1'b1);
    repeat (SETTLE - 1) tick();
    chk("R7 still settling", 2'b11, 2'b11, 2'b11, 1'b1);
    tick();
    chk("R7 released together", 2'b11, 2'b11, 2'b00, 1'b1);

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][14:13], VEC[k][12:11], VEC[k][10:9], VEC[k][8:7]);
      tick();
      chk($sformatf("R1/R2/R3/R4/R9/R10 vector %0d", k),
          VEC[k][6:5], VEC[k][4:3], VEC[k][2:1], VEC[k][0]);
    end

    // R9: one channel waking turns the buffer back on
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R9 ch0 wake buffer on", 2'b01, 2'b01, 2'b11, 1'b1);
    repeat (SETTLE - 1) tick();
    chk("R7 ch0 held", 2'b01, 2'b01, 2'b11, 1'b1);
    tick();
    chk("R7 ch0 released", 2'b01, 2'b01, 2'b10, 1'b1);

    // R8 abort on ch1, R12 ch0 untouched
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    repeat (3) tick();
    chk("R8 ch1 settling", 2'b11, 2'b11, 2'b10, 1'b1);
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R8 R12 abort ch1", 2'b01, 2'b01, 2'b10, 1'b1);
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    repeat (SETTLE) tick();
    chk("R8 settle restarted", 2'b11, 2'b11, 2'b10, 1'b1);
    tick();
    chk("R8 ch1 released", 2'b11, 2'b11, 2'b00, 1'b1);

    // R5 cancel pending synchronous request on ch1
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R5 pending keeps power", 2'b11, 2'b11, 2'b00, 1'b1);
    drive(2'b00, 2'b00, 2'b10, 2'b00);
    tick();
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    tick();
    drive(2'b00, 2'b00, 2'b10, 2'b00);
    tick();
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R5 cancelled, strobes ignored", 2'b11, 2'b11, 2'b00, 1'b1);

    // R6 switch to asynchronous while pending
    drive(2'b10, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R6 pending", 2'b11, 2'b11, 2'b00, 1'b1);
    drive(2'b10, 2'b10, 2'b00, 2'b00);
    tick();
    chk("R6 async while pending", 2'b01, 2'b01, 2'b10, 1'b1);

    // R10 counter reset across the ch1 settling expiry edge
    drive(2'b00, 2'b00, 2'b00, 2'b10);
    repeat (SETTLE + 1) tick();
    chk("R10 reset overrides release", 2'b11, 2'b11, 2'b10, 1'b1);
    drive(2'b00, 2'b00, 2'b00, 2'b00);
    tick();
    chk("R10 reset cleared", 2'b11, 2'b11, 2'b00, 1'b1);

    // R3 R9 R12 ch0 async down, ch1 keeps buffer alive
    drive(2'b01, 2'b01, 2'b00, 2'b00);
    tick();
    chk("R3 R9 R12 ch0 down only", 2'b10, 2'b10, 2'b01, 1'b1);

    finish_run();
  end

endmodule